// File: doc/BRIEF.md
# Byte-Stream Memory Command Decoder

This block sits behind a host byte link and turns a stream of 8-bit command bytes into four-byte accesses on a small on-chip byte store that models a burst-of-four DRAM. Incoming bytes arrive on a valid/ready stream. A read command is four bytes long. A write command is eight bytes long: the same four header bytes followed by four data bytes. Bank, row and column fields are packed across the header bytes. The block unpacks them, performs the access, and sends the response back on a valid/ready output byte stream.

An access always covers four consecutive beats. These beats wrap inside the aligned group of four columns that holds the start column. A level input reports whether the memory has been initialized. The block samples it when it executes a command. If the flag is low, the command is refused: the store is left untouched and an error code replaces the opcode in the response.

Top module: `memcmd_decoder`

## Requirements
- R1: A first byte of 0x80 or 0x81 starts a read and 0x90 or 0x91 starts a write. Any other byte seen where an opcode is expected is accepted and dropped, and the parser treats the following byte as a new opcode candidate.
- R2: With header bytes h0..h3, row = {h0[0], h1, h2[7:4]} (13 bits), column = {h2[3:0], h3[7:2]} (10 bits) and bank = h3[1:0]. The store keeps the bank, the low ROW_KEEP row bits and the low COL_KEEP column bits, so addresses that differ only in higher bits reach the same byte.
- R3: Beat i of an access (i = 0..3) uses column {col[9:2], col[1:0]+i mod 4}, so a start at column 1 touches columns 1, 2, 3, 0.
- R4: When a write executes with the memory initialized, data byte i is stored at beat i. The response is eight bytes: the four data bytes in arrival order, then h0, h1, h2, h3 exactly as received.
- R5: When a read executes with the memory initialized, the response is the four stored bytes in beat order 0..3.
- R6: A command that executes while mem_init is low changes no stored byte. A refused read answers 0xE7, h1, h2, h3. A refused write answers its four data bytes, then 0xE7, h1, h2, h3.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R8: in_ready is low from the cycle after a command's last byte is accepted until the last response byte has been taken.
- R9: After reset every stored byte is zero, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_init | input | 1 | Memory initialized flag, sampled when a command executes |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Decoder can accept a command byte |
| out_valid | output | 1 | Response byte valid |
| out_data | output | 8 | Response byte |
| out_ready | input | 1 | Consumer accepts the response byte |

## Verification
The bench builds the block with its defaults of ROW_KEEP = 2 and COL_KEEP = 4, which gives a 256-byte store. With the store this small, a command that sets the top row bit through the opcode and fills the upper column nibble still lands on bytes written earlier through an all-low address, so the aliasing rule and the opcode-held row bit are covered by one read. A second bank at the same row and column shows that the bank field separates data. Output stalls come from a pseudo-random ready pattern, so the hold rule is exercised inside both four-byte and eight-byte responses.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;
  localparam logic [7:0] OPC_READ  = 8'h80;
  localparam logic [7:0] OPC_WRITE = 8'h90;
  localparam logic [7:0] ERR_CODE  = 8'hE7;
  localparam int         BANK_W    = 2;
  localparam int         ROW_W     = 13;
  localparam int         COL_W     = 10;

  typedef enum logic [2:0] {P_OPC, P_HDR, P_DATA, P_EXEC, P_WAIT} pstate_t;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } addr_t;
endpackage

// File: rtl/memcmd_parser.sv
module memcmd_parser
  import memcmd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            resp_busy,
  output logic            in_ready,
  output logic            go,
  output logic            is_wr,
  output logic [3:0][7:0] hdr,
  output logic [3:0][7:0] dat
);
  pstate_t         state_q, state_n;
  logic [1:0]      cnt_q, cnt_n;
  logic [3:0][7:0] hdr_q, dat_q;
  logic            acc, op_ok, hdr_we, dat_we;

  assign in_ready = (state_q == P_OPC) || (state_q == P_HDR) || (state_q == P_DATA);
  assign acc      = in_valid && in_ready;
  assign op_ok    = (in_data[7:1] == OPC_READ[7:1]) || (in_data[7:1] == OPC_WRITE[7:1]);
  assign hdr_we   = acc && (((state_q == P_OPC) && op_ok) || (state_q == P_HDR));
  assign dat_we   = acc && (state_q == P_DATA);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    case (state_q)
      P_OPC: if (acc && op_ok) begin
        state_n = P_HDR;
        cnt_n   = 2'd1;
      end
      P_HDR: if (acc) begin
        cnt_n = cnt_q + 2'd1;
        if (cnt_q == 2'd3) state_n = hdr_q[0][4] ? P_DATA : P_EXEC;
      end
      P_DATA: if (acc) begin
        cnt_n = cnt_q + 2'd1;
        if (cnt_q == 2'd3) state_n = P_EXEC;
      end
      P_EXEC: state_n = P_WAIT;
      P_WAIT: if (!resp_busy) state_n = P_OPC;
      default: state_n = P_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= P_OPC;
      cnt_q   <= 2'd0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      dat_q <= '0;
    end else begin
      if (hdr_we) hdr_q[cnt_q] <= in_data;
      if (dat_we) dat_q[cnt_q] <= in_data;
    end
  end

  assign go    = (state_q == P_EXEC);
  assign is_wr = hdr_q[0][4];
  assign hdr   = hdr_q;
  assign dat   = dat_q;

  // R8
  no_accept_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_busy |-> !in_ready);
endmodule

// File: rtl/memcmd_store.sv
module memcmd_store
  import memcmd_pkg::*;
#(
  parameter int ROW_KEEP = 2,
  parameter int COL_KEEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  addr_t           addr,
  input  logic [3:0][7:0] wdata,
  output logic [3:0][7:0] rdata
);
  localparam int GRP_W = BANK_W + ROW_KEEP + COL_KEEP - 2;
  localparam int IDX_W = GRP_W + 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0]       mem_q [DEPTH];
  logic [GRP_W-1:0] group;
  logic [IDX_W-1:0] idx [4];

  assign group = {addr.bank, addr.row[ROW_KEEP-1:0], addr.col[COL_KEEP-1:2]};

  for (genvar b = 0; b < 4; b++) begin : g_beat
    logic [1:0] lane;
    assign lane     = addr.col[1:0] + 2'(b);
    assign idx[b]   = {group, lane};
    assign rdata[b] = mem_q[idx[b]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++) mem_q[idx[b]] <= wdata[b];
    end
  end

  // R3
  distinct_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (idx[0] != idx[1]) && (idx[0] != idx[2]) && (idx[0] != idx[3]));
endmodule

// File: rtl/memcmd_resp.sv
module memcmd_resp (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            len8,
  input  logic [7:0][7:0] bytes,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            busy
);
  logic [7:0][7:0] buf_q, buf_n;
  logic [3:0]      left_q, left_n;
  logic            take;

  assign out_valid = (left_q != 4'd0);
  assign out_data  = buf_q[0];
  assign busy      = out_valid;
  assign take      = out_valid && out_ready;

  always_comb begin
    buf_n  = buf_q;
    left_n = left_q;
    if (load) begin
      buf_n  = bytes;
      left_n = len8 ? 4'd8 : 4'd4;
    end else if (take) begin
      buf_n  = {8'h00, buf_q[7:1]};
      left_n = left_q - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '0;
      left_q <= '0;
    end else begin
      buf_q  <= buf_n;
      left_q <= left_n;
    end
  end

  // R7
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/memcmd_decoder.sv
module memcmd_decoder
  import memcmd_pkg::*;
#(
  parameter int ROW_KEEP = 2,
  parameter int COL_KEEP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_init,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready
);
  logic            go, is_wr, resp_busy, wr_en;
  logic [3:0][7:0] hdr, dat, rdata;
  logic [7:0][7:0] rbytes;
  logic [7:0]      echo0;
  addr_t           addr;

  memcmd_parser u_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .resp_busy(resp_busy), .in_ready(in_ready), .go(go), .is_wr(is_wr),
    .hdr(hdr), .dat(dat)
  );

  assign addr.row  = {hdr[0][0], hdr[1], hdr[2][7:4]};
  assign addr.col  = {hdr[2][3:0], hdr[3][7:2]};
  assign addr.bank = hdr[3][1:0];
  assign wr_en     = go && is_wr && mem_init;

  memcmd_store #(.ROW_KEEP(ROW_KEEP), .COL_KEEP(COL_KEEP)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(dat), .rdata(rdata)
  );

  assign echo0 = mem_init ? hdr[0] : ERR_CODE;

  always_comb begin
    if (is_wr) begin
      rbytes = {hdr[3], hdr[2], hdr[1], echo0, dat};
    end else if (mem_init) begin
      rbytes = {32'h0, rdata};
    end else begin
      rbytes = {32'h0, hdr[3], hdr[2], hdr[1], ERR_CODE};
    end
  end

  memcmd_resp u_resp (
    .clk(clk), .rst_n(rst_n), .load(go), .len8(is_wr), .bytes(rbytes),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .busy(resp_busy)
  );

  // R6
  refused_read_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !is_wr && !mem_init |=> out_valid && (out_data == ERR_CODE));

  // R4
  write_echo_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && is_wr |=> out_valid && (out_data == $past(dat[0])));
endmodule

// File: tb/tb_memcmd_decoder.sv
module tb_memcmd_decoder;
  localparam int RK = 2;
  localparam int CK = 4;

  logic clk, rst_n, mem_init, in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data, out_data;

  memcmd_decoder #(.ROW_KEEP(RK), .COL_KEEP(CK)) dut (
    .clk(clk), .rst_n(rst_n), .mem_init(mem_init), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] model [256];
  logic [15:0] lfsr;
  bit stall_seen;
  logic [7:0] stall_data;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int midx(input logic [7:0] op, b1, b2, b3, input int beat);
    logic [12:0] row;
    logic [9:0]  col;
    int grp;
    row = {op[0], b1, b2[7:4]};
    col = {b2[3:0], b3[7:2]};
    grp = (int'(b3[1:0]) << RK) | (int'(row) & ((1 << RK) - 1));
    grp = (grp << (CK - 2)) | ((int'(col) & ((1 << CK) - 1)) >> 2);
    return (grp << 2) | ((int'(col) + beat) & 3);
  endfunction

  task automatic push(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    bit ok;
    in_data  = b;
    in_valid = 1'b1;
    do begin
      ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] op, b1, b2, b3, d0, d1, d2, d3, input string tag);
    logic [7:0] d [4];
    d = '{d0, d1, d2, d3};
    for (int i = 0; i < 4; i++) push(d[i], tag);
    push(mem_init ? op : 8'hE7, tag);
    push(b1, tag); push(b2, tag); push(b3, tag);
    if (mem_init) for (int i = 0; i < 4; i++) model[midx(op, b1, b2, b3, i)] = d[i];
    send(op); send(b1); send(b2); send(b3);
    for (int i = 0; i < 4; i++) send(d[i]);
  endtask

  task automatic do_read(input logic [7:0] op, b1, b2, b3, input string tag);
    if (mem_init) begin
      for (int i = 0; i < 4; i++) push(model[midx(op, b1, b2, b3, i)], tag);
    end else begin
      push(8'hE7, tag); push(b1, tag); push(b2, tag); push(b3, tag);
    end
    send(op); send(b1); send(b2); send(b3);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || out_valid || !in_ready) @(negedge clk);
  endtask

  // pseudo-random output readiness, changed just after each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr      <= 16'hACE1;
      out_ready <= 1'b0;
    end else begin
      lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= lfsr[0] | lfsr[3];
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_seen) begin
        check(out_valid && out_data == stall_data, "R7 hold", out_data, stall_data);
      end
      stall_seen = out_valid && !out_ready;
      stall_data = out_data;
      if (out_valid) check(!in_ready, "R8 in_ready low", in_ready, 0);
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected byte", out_data, 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
    end else begin
      stall_seen = 1'b0;
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    check(1'b0, "watchdog", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) model[k] = 8'h00;
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; mem_init = 1'b0;
    stall_seen = 1'b0; stall_data = 8'h00;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 refused write and read while not initialized
    do_write(8'h90, 8'h00, 8'h20, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44, "R6 refused write");
    do_read(8'h80, 8'h00, 8'h20, 8'h01, "R6 refused read");
    drain();
    mem_init = 1'b1;
    // R6/R9 store untouched, still zero
    do_read(8'h80, 8'h00, 8'h20, 8'h01, "R6 R9 store unchanged");
    // R4 R5 write then read at column 0, bank 1
    do_write(8'h90, 8'h00, 8'h20, 8'h01, 8'hA0, 8'hA1, 8'hA2, 8'hA3, "R4 write echo");
    do_read(8'h80, 8'h00, 8'h20, 8'h01, "R5 read back");
    // R3 write starting at column 1 wraps onto column 0
    do_write(8'h90, 8'h00, 8'h20, 8'h05, 8'hB0, 8'hB1, 8'hB2, 8'hB3, "R3 wrapped write");
    do_read(8'h80, 8'h00, 8'h20, 8'h01, "R3 wrapped read");
    // R1 junk bytes ahead of a read are dropped
    send(8'h55); send(8'h82); send(8'hE7);
    do_read(8'h81, 8'h00, 8'h20, 8'h09, "R1 resync read");
    // R2 aliasing through high row and column bits, and bank separation
    do_read(8'h91 & 8'h81, 8'h5A, 8'h6F, 8'hC1, "R2 alias read");
    do_read(8'h80, 8'h00, 8'h20, 8'h02, "R2 other bank");
    do_write(8'h91, 8'h03, 8'h7E, 8'hFE, 8'hC0, 8'hC1, 8'hC2, 8'hC3, "R2 R4 high write");
    do_read(8'h81, 8'h03, 8'h7E, 8'hF2, "R2 R3 high read");
    drain();
    mem_init = 1'b0;
    do_read(8'h81, 8'h03, 8'h7E, 8'hF2, "R6 refused late read");
    drain();
    check(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule